// File: doc/BRIEF.md
# Configurable Capture Trigger

This block decides the moment a logic capture begins. It watches one line of a probe bus, chosen by a select value, and raises a sticky fired flag once the chosen trigger condition is met. Further logic uses this flag to start the sample clock. The flag stays high until the unit is cleared.

Four trigger conditions are available. Three of them look for an edge on the watched line: a rising edge, a falling edge, or a change in either direction. The fourth is a serial pattern match. In that mode a separate trigger clock and data pair shift bits into a register, and the unit fires when the most recent bits equal a programmed pattern.

All asynchronous inputs pass through two-flop synchronizers into the system clock domain. The unit has no streaming data path, so it has no valid/ready handshake and no back-pressure rules. Every pin is a plain control or status level. To use the unit, hold `clear_in` high while setting the mode, select and pattern, then drop `clear_in` to arm it.

Top module: `capture_trigger`

## Requirements
- R1: After reset `fired_out` is 0.
- R2: While `clear_in` is 1, `fired_out` is 0 from the next clock edge onward, and no condition can set it. Clearing also empties the serial shift register, so bits received before a clear never count toward a match.
- R3: In mode code 0 (rising), a 0-to-1 change on the selected probe line sets `fired_out`. If the change is applied just after a clock edge, `fired_out` is still 0 after the next two edges and is 1 after the third.
- R4: In mode code 1 (falling), a 1-to-0 change on the selected probe line sets `fired_out`.
- R5: In mode code 2 (change), a change in either direction on the selected probe line sets `fired_out`.
- R6: Once set, `fired_out` stays 1 whatever the inputs do, until `clear_in` is driven high.
- R7: Mode, select and pattern are captured only while `clear_in` is 1. Changing them while the unit is armed has no effect until the next clear.
- R8: Probe lines other than the selected one never cause a trigger.
- R9: In mode code 3 (sequence), each rising edge of `seq_clk_in` shifts the level of `seq_dat_in` into the LSB of an 8-bit register, and earlier bits move toward the MSB. The unit fires when the register equals `pattern_in`, so the first bit received ends up in bit 7.
- R10: In sequence mode no match is possible until 8 bits have been shifted in since the last clear. This holds even when the pattern is all zeros.
- R11: In sequence mode the unit compares after every shift, so it can fire on any bit from the eighth onward.
- R12: Edge modes ignore the sequence pins, and sequence mode ignores the probe lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe_in | input | NPROBE | Asynchronous probe lines |
| sel_in | input | SELW | Index of the watched probe line |
| mode_in | input | 2 | Trigger mode: 0 rising, 1 falling, 2 change, 3 sequence |
| pattern_in | input | PAT_W | Pattern for sequence mode |
| seq_clk_in | input | 1 | External trigger clock, asynchronous |
| seq_dat_in | input | 1 | External trigger serial data, asynchronous |
| clear_in | input | 1 | 1 = clear and disarm; 0 = armed |
| fired_out | output | 1 | Sticky trigger flag |

## Verification
A corrupted latch shows up at once as `fired_out` changing while the inputs are quiet, or as the flag falling while the unit is armed. A wrong captured configuration shows up as a trigger that follows the wrong line or edge, which is visible at most three cycles after the stimulus. A shift register or fill count that goes out of step shows up as a match that fires one bit early or late. For that reason the bench checks `fired_out` after every serial bit, both before and after the expected match.

// File: rtl/capture_trigger_pkg.sv
package capture_trigger_pkg;
  typedef enum logic [1:0] {
    TM_RISE   = 2'd0,
    TM_FALL   = 2'd1,
    TM_CHANGE = 2'd2,
    TM_SEQ    = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/ct_sync.sv
module ct_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ct_edge_sel.sv
module ct_edge_sel
  import capture_trigger_pkg::*;
#(
  parameter int NPROBE = 8,
  parameter int SELW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPROBE-1:0] lines_s,
  input  logic [SELW-1:0]   sel,
  input  trig_mode_e        mode,
  output logic              edge_hit
);
  logic line_now;
  logic line_prev;

  // Indices past the top of the bus read as 0.
  always_comb begin
    line_now = 1'b0;
    for (int i = 0; i < NPROBE; i++)
      if (sel == SELW'(i)) line_now = lines_s[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev <= 1'b0;
    else        line_prev <= line_now;
  end

  always_comb begin
    unique case (mode)
      TM_RISE:   edge_hit = line_now & ~line_prev;
      TM_FALL:   edge_hit = ~line_now & line_prev;
      TM_CHANGE: edge_hit = line_now ^ line_prev;
      default:   edge_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ct_seq_shift.sv
module ct_seq_shift #(
  parameter int PAT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FILLW      = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_clk_in,
  input  logic             seq_dat_in,
  input  logic             clear,
  input  logic [PAT_W-1:0] pattern,
  output logic             seq_match,
  output logic [FILLW-1:0] fill
);
  logic [1:0]       pair_s;
  logic             sclk_prev;
  logic             shift_ev;
  logic             shifted_q;
  logic [PAT_W-1:0] shreg;

  ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({seq_clk_in, seq_dat_in}),
    .q    (pair_s)
  );

  assign shift_ev = pair_s[1] & ~sclk_prev & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      shreg     <= '0;
      fill      <= '0;
      shifted_q <= 1'b0;
    end else begin
      sclk_prev <= pair_s[1];
      shifted_q <= shift_ev;
      if (clear) begin
        shreg <= '0;
        fill  <= '0;
      end else if (shift_ev) begin
        shreg <= {shreg[PAT_W-2:0], pair_s[0]};
        if (fill != FILLW'(PAT_W)) fill <= fill + 1'b1;
      end
    end
  end

  assign seq_match = shifted_q & (fill == FILLW'(PAT_W)) & (shreg == pattern);
endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
  import capture_trigger_pkg::*;
#(
  parameter int NPROBE      = 8,
  parameter int PAT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SELW       = (NPROBE > 1) ? $clog2(NPROBE) : 1,
  localparam int FILLW      = $clog2(PAT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPROBE-1:0] probe_in,
  input  logic [SELW-1:0]   sel_in,
  input  logic [1:0]        mode_in,
  input  logic [PAT_W-1:0]  pattern_in,
  input  logic              seq_clk_in,
  input  logic              seq_dat_in,
  input  logic              clear_in,
  output logic              fired_out
);
  trig_mode_e        mode_q;
  logic [SELW-1:0]   sel_q;
  logic [PAT_W-1:0]  pat_q;
  logic              arm_q;
  logic [NPROBE-1:0] probe_s;
  logic              edge_hit;
  logic              seq_match;
  logic [FILLW-1:0]  seq_fill;
  logic              hit_any;

  // Configuration is captured only while the unit is cleared.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_RISE;
      sel_q  <= '0;
      pat_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= ~clear_in;
      if (clear_in) begin
        mode_q <= trig_mode_e'(mode_in);
        sel_q  <= sel_in;
        pat_q  <= pattern_in;
      end
    end
  end

  ct_sync #(.W(NPROBE), .STAGES(SYNC_STAGES)) u_probe_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (probe_in),
    .q    (probe_s)
  );

  ct_edge_sel #(.NPROBE(NPROBE), .SELW(SELW)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_s (probe_s),
    .sel     (sel_q),
    .mode    (mode_q),
    .edge_hit(edge_hit)
  );

  ct_seq_shift #(.PAT_W(PAT_W), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_clk_in(seq_clk_in),
    .seq_dat_in(seq_dat_in),
    .clear     (clear_in),
    .pattern   (pat_q),
    .seq_match (seq_match),
    .fill      (seq_fill)
  );

  // arm_q holds off detection for one cycle after release, so that the
  // previous-value register has seen the newly selected line.
  assign hit_any = arm_q & ((mode_q == TM_SEQ) ? seq_match : edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fired_out <= 1'b0;
    else if (clear_in) fired_out <= 1'b0;
    else if (hit_any)  fired_out <= 1'b1;
  end
endmodule

// File: rtl/capture_trigger_checker.sv
module capture_trigger_checker
  import capture_trigger_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int SELW  = 3,
  parameter int FILLW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_in,
  input logic             fired_out,
  input trig_mode_e       mode_q,
  input logic [SELW-1:0]  sel_q,
  input logic [PAT_W-1:0] pat_q,
  input logic             hit_any,
  input logic [FILLW-1:0] seq_fill
);
  assert_clear_forces_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_in |=> !fired_out);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_out && !clear_in) |=> fired_out);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_in |=> ($stable(mode_q) && $stable(sel_q) && $stable(pat_q)));

  assert_fire_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired_out) |-> $past(hit_any));

  assert_fill_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fill <= FILLW'(PAT_W));

  assert_seq_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fired_out) && mode_q == TM_SEQ) |-> ($past(seq_fill) == FILLW'(PAT_W)));
endmodule

bind capture_trigger capture_trigger_checker #(
  .PAT_W(PAT_W),
  .SELW (SELW),
  .FILLW(FILLW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear_in (clear_in),
  .fired_out(fired_out),
  .mode_q   (mode_q),
  .sel_q    (sel_q),
  .pat_q    (pat_q),
  .hit_any  (hit_any),
  .seq_fill (seq_fill)
);

// File: tb/capture_trigger_tb_top.sv
module capture_trigger_tb_top;
  localparam int CLK_P  = 10;
  localparam int NPROBE = 8;
  localparam int PAT_W  = 8;
  localparam int SELW   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NPROBE-1:0] probe_in = '0;
  logic [SELW-1:0]   sel_in = '0;
  logic [1:0]        mode_in = '0;
  logic [PAT_W-1:0]  pattern_in = '0;
  logic              seq_clk_in = 1'b0;
  logic              seq_dat_in = 1'b0;
  logic              clear_in = 1'b1;
  logic              fired_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  capture_trigger #(.NPROBE(NPROBE), .PAT_W(PAT_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_in  (probe_in),
    .sel_in    (sel_in),
    .mode_in   (mode_in),
    .pattern_in(pattern_in),
    .seq_clk_in(seq_clk_in),
    .seq_dat_in(seq_dat_in),
    .clear_in  (clear_in),
    .fired_out (fired_out)
  );

  // Monitor: compare the oldest expectation away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (fired_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: fired_out=%0b expected=%0b", it.tag, fired_out, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_fired(logic e, string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic setup(logic [1:0] m, logic [SELW-1:0] s, logic [PAT_W-1:0] p);
    clear_in   = 1'b1;
    mode_in    = m;
    sel_in     = s;
    pattern_in = p;
    tick(4);
    clear_in = 1'b0;
    tick(3);
  endtask

  task automatic send_bit(logic b, logic e, string tag);
    seq_dat_in = b;
    tick(1);
    seq_clk_in = 1'b1;
    tick(3);
    seq_clk_in = 1'b0;
    tick(3);
    expect_fired(e, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, fired_out=%0b expected=done", fired_out);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_fired(1'b0, "R1 reset state");
    rst_n = 1'b1;
    tick(2);
    expect_fired(1'b0, "R1 after reset release");

    // Rising mode on line 2
    setup(2'd0, 3'd2, 8'h00);
    expect_fired(1'b0, "R3 armed idle");
    probe_in[5] = 1'b1;
    tick(5);
    expect_fired(1'b0, "R8 unselected line rise");
    seq_clk_in = 1'b1; tick(4); seq_clk_in = 1'b0; tick(4);
    expect_fired(1'b0, "R12 seq pins in edge mode");
    probe_in[2] = 1'b1;
    tick(2);
    expect_fired(1'b0, "R3 latency not yet");
    tick(1);
    expect_fired(1'b1, "R3 fires on third edge");
    probe_in[2] = 1'b0; tick(4); probe_in[2] = 1'b1; tick(4);
    expect_fired(1'b1, "R6 sticky under activity");

    clear_in = 1'b1;
    tick(1);
    expect_fired(1'b0, "R2 clear drops flag");
    probe_in[2] = 1'b0; tick(3); probe_in[2] = 1'b1; tick(4);
    expect_fired(1'b0, "R2 no set while clear");

    // Falling mode; armed-time config changes are ignored
    probe_in = '0;
    probe_in[2] = 1'b1;
    setup(2'd1, 3'd2, 8'h00);
    mode_in = 2'd0;
    sel_in  = 3'd5;
    probe_in[5] = 1'b1;
    tick(5);
    expect_fired(1'b0, "R7 armed reconfig ignored");
    probe_in[2] = 1'b0;
    tick(4);
    expect_fired(1'b1, "R4 falling edge fires");

    // Change mode, both directions
    probe_in = '0;
    setup(2'd2, 3'd2, 8'h00);
    probe_in[2] = 1'b1;
    tick(4);
    expect_fired(1'b1, "R5 change up fires");
    setup(2'd2, 3'd2, 8'h00);
    expect_fired(1'b0, "R5 rearmed idle");
    probe_in[2] = 1'b0;
    tick(4);
    expect_fired(1'b1, "R5 change down fires");

    // Sequence mode, pattern A5
    setup(2'd3, 3'd2, 8'hA5);
    probe_in[2] = 1'b1; tick(4); probe_in[2] = 1'b0; tick(4);
    expect_fired(1'b0, "R12 probe in seq mode");
    send_bit(1'b1, 1'b0, "R9 bit1");
    send_bit(1'b0, 1'b0, "R9 bit2");
    send_bit(1'b1, 1'b0, "R9 bit3");
    send_bit(1'b0, 1'b0, "R9 bit4");
    send_bit(1'b0, 1'b0, "R9 bit5");
    send_bit(1'b1, 1'b0, "R9 bit6");
    send_bit(1'b0, 1'b0, "R9 bit7");
    send_bit(1'b1, 1'b1, "R9 match on bit8");

    // All-zero pattern needs eight bits
    setup(2'd3, 3'd0, 8'h00);
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0, "R10 zero pattern early");
    send_bit(1'b0, 1'b1, "R10 zero pattern eighth");

    // Match after prefix: 1111 then 00111100
    setup(2'd3, 3'd0, 8'h3C);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, "R11 prefix");
    send_bit(1'b0, 1'b0, "R11 bit5");
    send_bit(1'b0, 1'b0, "R11 bit6");
    send_bit(1'b1, 1'b0, "R11 bit7");
    send_bit(1'b1, 1'b0, "R11 bit8");
    send_bit(1'b1, 1'b0, "R11 bit9");
    send_bit(1'b1, 1'b0, "R11 bit10");
    send_bit(1'b0, 1'b0, "R11 bit11");
    send_bit(1'b0, 1'b1, "R11 match on bit12");

    // Clear empties the shift register
    setup(2'd3, 3'd0, 8'hFF);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, "R2 before clear");
    setup(2'd3, 3'd0, 8'hFF);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, "R2 stale bits dropped");
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, "R2 refill");
    send_bit(1'b1, 1'b1, "R2 full after refill");

    tick(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule